// File: doc/BRIEF.md
# Indexed Multi-Word Load Sequencer

This block carries out a string load whose word count is known only at run time. It receives the decoded register numbers of an instruction: a first destination, a base and an index. Through one register-file read port it fetches the base value and then the index value. It adds them to form a 32-bit start address. A base field of zero stands for the constant zero, not for the contents of register 0.

The count of words comes from the five low bits of the index value, and a value of zero means a full set of 32 words. For each word the block issues a single read on a simple request/valid memory port. When the data returns, it writes the word through a register-file write port to the next destination register. Destination numbers wrap from 31 back to 0.

A start pulse launches the sequence. A busy flag covers the whole run, and a one-cycle done pulse marks its end. The block holds at most one memory read in flight.

Top module: `mwload_seq`

## Requirements
- R1: When the base field is 0, the start address equals the index register's value, whatever register 0 holds.
- R2: When the base field is nonzero, the start address is base value plus index value, modulo 2^32.
- R3: The word count is the index value's bits [4:0]; the value 0 selects 32 words.
- R4: The read for word i (i from 0) carries address start + 4*i, modulo 2^32.
- R5: Word i is written to register (destination field + i) mod 32.
- R6: The base and index values are read once, before any register write; later writes to those registers change neither the address nor the count.
- R7: `mem_req_o` is a one-cycle pulse. A new request never appears before the previous read has returned and been written.
- R8: `rf_we_o` is high only in a cycle where `mem_rvalid_i` is high while the block waits for data, and `rf_wdata_o` then equals `mem_rdata_i`.
- R9: `done_o` is high for exactly one cycle, the cycle after the last register write. `busy_o` is high from the cycle after an accepted start through the done cycle, and low in the cycle after.
- R10: A start pulse is ignored while `busy_o` is high, including during the done cycle.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dst_sel_i | input | 5 | First destination register number |
| base_sel_i | input | 5 | Base register number; 0 means a literal zero |
| idx_sel_i | input | 5 | Index register number, which also supplies the count |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 32 | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory word read request, one cycle |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The bench goes after these cases:
- A count field of zero: a design that treated it literally would finish with no writes rather than 32.
- A destination near 31: a design that dropped the wrap would write past the register range or stall.
- A base field of zero with a nonzero register 0: a design that read the register would start at a shifted address.
- Destinations that overwrite the base and index registers mid-run: a design that re-read them would change its stride or its stopping point.
- An address that crosses 2^32 and start pulses issued during busy and during done: these catch lost wraparound and restarted sequences.

// File: rtl/mwload_pkg.sv
package mwload_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_BASE = 3'd1,
    ST_RD_IDX  = 3'd2,
    ST_REQ     = 3'd3,
    ST_WAIT    = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_e;
endpackage

// File: rtl/mwload_fsm.sv
module mwload_fsm
  import mwload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rvalid_i,
  input  logic last_i,
  output logic accept_o,
  output logic cap_base_o,
  output logic cap_idx_o,
  output logic issue_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_RD_BASE;
      ST_RD_BASE: state_d = ST_RD_IDX;
      ST_RD_IDX:  state_d = ST_REQ;
      ST_REQ:     state_d = ST_WAIT;
      ST_WAIT:    if (rvalid_i) state_d = last_i ? ST_DONE : ST_REQ;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign cap_base_o = (state_q == ST_RD_BASE);
  assign cap_idx_o  = (state_q == ST_RD_IDX);
  assign issue_o    = (state_q == ST_REQ);
  assign step_o     = (state_q == ST_WAIT) && rvalid_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  // R9: done lasts one cycle and is followed by idle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R10: once busy, only the done cycle can lead back to idle
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
endmodule

// File: rtl/mwload_addr.sv
module mwload_addr #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_base_i,
  input  logic            cap_idx_i,
  input  logic            base_zero_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic            step_i,
  output logic [XLEN-1:0] ea_o
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

  logic [XLEN-1:0] base_q, base_d;
  logic [XLEN-1:0] ea_q, ea_d;
  logic            base_en, ea_en;

  assign base_en = cap_base_i;
  assign base_d  = base_zero_i ? '0 : rdata_i;
  assign ea_en   = cap_idx_i | step_i;
  assign ea_d    = cap_idx_i ? (base_q + rdata_i) : (ea_q + WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ea_q <= '0;
    else if (ea_en) ea_q <= ea_d;
  end

  assign ea_o = ea_q;

  // capture and stepping never collide
  assert_no_cap_while_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_idx_i && step_i));
endmodule

// File: rtl/mwload_cnt.sv
module mwload_cnt #(
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_dst_i,
  input  logic [RAW-1:0] dst_i,
  input  logic           cap_cnt_i,
  input  logic [RAW-1:0] cnt_bits_i,
  input  logic           step_i,
  output logic [RAW-1:0] waddr_o,
  output logic           last_o
);
  localparam logic [RAW:0] FULL = (RAW+1)'(1) << RAW;
  localparam logic [RAW:0] ONE  = (RAW+1)'(1);

  logic [RAW-1:0] dst_q, dst_d;
  logic [RAW:0]   rem_q, rem_d;
  logic           dst_en, rem_en;

  assign dst_en = load_dst_i | step_i;
  assign dst_d  = load_dst_i ? dst_i : dst_q + RAW'(1);
  assign rem_en = cap_cnt_i | step_i;
  assign rem_d  = cap_cnt_i ? ((cnt_bits_i == '0) ? FULL : {1'b0, cnt_bits_i})
                            : rem_q - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dst_q <= '0;
    else if (dst_en) dst_q <= dst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign waddr_o = dst_q;
  assign last_o  = (rem_q == ONE);

  // R3: a step never happens with nothing left to load
  assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q != '0));
  // R3: the remaining count never exceeds a full set
  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= FULL);
endmodule

// File: rtl/mwload_seq.sv
module mwload_seq #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [RAW-1:0]  dst_sel_i,
  input  logic [RAW-1:0]  base_sel_i,
  input  logic [RAW-1:0]  idx_sel_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [RAW-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i
);
  logic accept, cap_base, cap_idx, issue, step, last;
  logic [RAW-1:0] base_fld_q, idx_fld_q;

  mwload_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rvalid_i   (mem_rvalid_i),
    .last_i     (last),
    .accept_o   (accept),
    .cap_base_o (cap_base),
    .cap_idx_o  (cap_idx),
    .issue_o    (issue),
    .step_o     (step),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // register numbers held for the two read cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_fld_q <= '0;
      idx_fld_q  <= '0;
    end else if (accept) begin
      base_fld_q <= base_sel_i;
      idx_fld_q  <= idx_sel_i;
    end
  end

  assign rf_raddr_o = cap_base ? base_fld_q : idx_fld_q;

  mwload_addr #(.XLEN(XLEN)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_base_i  (cap_base),
    .cap_idx_i   (cap_idx),
    .base_zero_i (base_fld_q == '0),
    .rdata_i     (rf_rdata_i),
    .step_i      (step),
    .ea_o        (mem_addr_o)
  );

  mwload_cnt #(.RAW(RAW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_dst_i (accept),
    .dst_i      (dst_sel_i),
    .cap_cnt_i  (cap_idx),
    .cnt_bits_i (rf_rdata_i[RAW-1:0]),
    .step_i     (step),
    .waddr_o    (rf_waddr_o),
    .last_o     (last)
  );

  assign mem_req_o  = issue;
  assign rf_we_o    = step;
  assign rf_wdata_o = mem_rdata_i;

  // R7: requests are single-cycle pulses
  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);
  // R7: no request in the cycle a word is written
  assert_req_not_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> !mem_req_o);
  // R8: writes only with valid memory data
  assert_we_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_rvalid_i && rf_wdata_o == mem_rdata_i));
  // R9: done follows a register write
  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rf_we_o));
  // R9: memory traffic only while busy
  assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);
endmodule

// File: tb/tb_mwload_seq.sv
module tb_mwload_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  dst_sel_i = '0, base_sel_i = '0, idx_sel_i = '0;
  logic        busy_o, done_o, rf_we_o, mem_req_o;
  logic [4:0]  rf_raddr_o, rf_waddr_o;
  logic [31:0] rf_rdata_i, rf_wdata_o, mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  logic [31:0] rf [32];
  logic [31:0] init_rf [32];
  logic [31:0] ref_rf [32];
  logic        do_load = 1'b0;

  int total = 0, bad = 0, cycles = 0;
  bit active = 1'b0;
  logic [31:0] cur_ea;
  logic [4:0]  cur_rd;
  int cur_n, rcnt, wcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwload_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dst_sel_i(dst_sel_i), .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i),
    .busy_o(busy_o), .done_o(done_o),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h3c5a_9e17;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // register file model
  assign rf_rdata_i = rf[rf_raddr_o];
  always @(posedge clk) begin
    if (do_load) begin
      for (int k = 0; k < 32; k++) rf[k] <= init_rf[k];
    end else if (rf_we_o) begin
      rf[rf_waddr_o] <= rf_wdata_o;
    end
  end

  // memory model: random latency of one to three cycles
  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  int          lat = 0;
  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (mem_req_o) begin
      pend  <= 1'b1;
      paddr <= mem_addr_o;
      lat   <= int'($urandom_range(0, 2));
    end else if (pend) begin
      if (lat == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= memfn(paddr);
        pend <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (active && mem_req_o) begin
      chk(mem_addr_o == cur_ea + 32'(4 * rcnt), "R4", "request address",
          mem_addr_o, cur_ea + 32'(4 * rcnt));
      chk(rcnt == wcnt, "R7", "request before previous write", rcnt, wcnt);
      rcnt++;
    end
    if (active && rf_we_o) begin
      chk(rf_waddr_o == 5'(cur_rd + wcnt), "R5", "write register",
          rf_waddr_o, 5'(cur_rd + wcnt));
      chk(rf_wdata_o == memfn(cur_ea + 32'(4 * wcnt)), "R8", "write data",
          rf_wdata_o, memfn(cur_ea + 32'(4 * wcnt)));
      wcnt++;
    end
  end

  // global watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input logic [4:0] rd, input logic [4:0] ra,
                     input logic [4:0] rb, input bit poke, input string tag);
    logic [31:0] base, idx;
    int guard;
    @(negedge clk);
    do_load = 1'b1;
    @(negedge clk);
    do_load = 1'b0;
    base = (ra == 0) ? 32'h0 : init_rf[ra];
    idx  = init_rf[rb];
    cur_ea = base + idx;
    cur_n  = (idx[4:0] == 0) ? 32 : int'(idx[4:0]);
    cur_rd = rd;
    for (int k = 0; k < 32; k++) ref_rf[k] = init_rf[k];
    for (int i = 0; i < cur_n; i++) ref_rf[5'(rd + i)] = memfn(cur_ea + 32'(4 * i));
    rcnt = 0; wcnt = 0; active = 1'b1;
    start_i = 1'b1; dst_sel_i = rd; base_sel_i = ra; idx_sel_i = rb;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", {tag, " busy after start"}, busy_o, 1);
    guard = 0;
    while (!done_o && guard < 3000) begin
      if (poke && guard == 7) begin
        start_i = 1'b1; dst_sel_i = rd ^ 5'd9; base_sel_i = rb; idx_sel_i = ra;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9", {tag, " done seen"}, done_o, 1);
    chk(wcnt == cur_n, "R3", {tag, " word count"}, wcnt, cur_n);
    chk(busy_o == 1'b1, "R9", {tag, " busy in done cycle"}, busy_o, 1);
    if (poke) begin
      start_i = 1'b1; dst_sel_i = 5'd1; base_sel_i = 5'd2; idx_sel_i = 5'd3;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !busy_o, "R9", {tag, " idle after done"}, {busy_o, done_o}, 0);
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R10", {tag, " no restart"}, {busy_o, mem_req_o}, 0);
    active = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (rf[k] !== ref_rf[k]) begin
        chk(1'b0, "R5", {tag, " register file"}, rf[k], ref_rf[k]);
        break;
      end
      if (k == 31) chk(1'b1, "R5", {tag, " register file"}, 0, 0);
    end
  endtask

  task automatic fill_random();
    for (int k = 0; k < 32; k++) init_rf[k] = $urandom();
  endtask

  initial begin
    void'($urandom(32'd4242));
    fill_random();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({busy_o, done_o, mem_req_o, rf_we_o} == 4'b0, "R11", "reset outputs",
        {busy_o, done_o, mem_req_o, rf_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, mem_req_o, rf_we_o} == 4'b0, "R11", "after release",
        {busy_o, done_o, mem_req_o, rf_we_o}, 0);

    // R1: base field 0 with nonzero register 0
    fill_random(); init_rf[0] = 32'h1234_5670; init_rf[4] = 32'h0000_8008;
    run(5'd5, 5'd0, 5'd4, 1'b0, "R1 base-zero");
    // R3: count field zero loads 32 words
    fill_random(); init_rf[4] = 32'h0001_0000; init_rf[3] = 32'h0000_0100;
    run(5'd0, 5'd3, 5'd4, 1'b0, "R3 full-32");
    // R5: destination wrap
    fill_random(); init_rf[7] = 32'h0000_004a;
    run(5'd28, 5'd9, 5'd7, 1'b0, "R5 wrap");
    // R6: destinations overwrite base and index registers
    fill_random(); init_rf[3] = 32'h0000_2000; init_rf[4] = 32'h0000_0005;
    run(5'd2, 5'd3, 5'd4, 1'b0, "R6 overwrite");
    // R2: address wrap past 2^32
    fill_random(); init_rf[6] = 32'hffff_fff0; init_rf[8] = 32'h0000_0006;
    run(5'd10, 5'd6, 5'd8, 1'b0, "R2 addr-wrap");
    // R10: start during busy and during done
    fill_random(); init_rf[11] = 32'h0000_0c0c; init_rf[12] = 32'h0000_0007;
    run(5'd20, 5'd11, 5'd12, 1'b1, "R10 poke");
    // random mix
    for (int t = 0; t < 20; t++) begin
      fill_random();
      run(5'($urandom()), 5'($urandom()), 5'($urandom()), t[0], "random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule